// File: doc/BRIEF.md
# Double-Width Funnel Right Shifter

This unit shifts a destination operand to the right by a variable count. The bits that empty out at the top are not filled with zeros or copies of the sign bit. They are refilled from the low end of a second source operand, so the two operands act as one double-width value that slides past a window. The operand width is 16, 32 or 64 bits, chosen per operation by a size code. The count is first reduced: to six bits for a 64-bit operation while the wide-mode flag is high, and to five bits in every other case.

Next to the shifted value, the block produces six condition flags. Each flag has its own write enable, so the surrounding datapath knows which flags to commit and which to leave alone. Some combinations are architecturally undefined: a 16-bit operation whose reduced count goes past 16, and certain flags after some shifts. For these the block drives fixed, known values and raises a separate marker bit. There is one cycle of latency. An input strobe loads the operation into registers, and a matching output strobe follows on the next cycle.

Top module: `funnel_rshift`

## Requirements
- R1: The effective count is `cnt[5:0]` when `size_sel` selects 64 bits (code `2'b10` or `2'b11`) and `wide_mode` is 1. In every other case it is `cnt[4:0]`. Size code `2'b00` selects 16 bits and `2'b01` selects 32 bits.
- R2: An effective count of zero returns the destination, masked to the operand size, with `undef` = 0 and all of `flag_wen` = 0.
- R3: For an effective count C with 1 ≤ C ≤ S (S is the operand size), result bit i is `dst[i+C]` for i < S−C and `src[i+C−S]` for S−C ≤ i < S.
- R4: Result bits at and above position S are always 0.
- R5: The carry flag (`flag_val[0]`, enable `flag_wen[0]`) equals `dst[C−1]` and is enabled whenever 1 ≤ C ≤ S.
- R6: The sign flag (bit 4), zero flag (bit 3) and parity flag (bit 1) are enabled whenever 1 ≤ C ≤ S. Sign is result bit S−1. Zero is set when the result is zero. Parity is set when result bits 7..0 hold an even number of ones.
- R7: The overflow flag (bit 5) is enabled only when C = 1, and then equals `result[S−1] XOR dst[S−1]`. For C > 1 its enable and its value are 0.
- R8: The adjust flag (bit 2) is never enabled and always reads 0.
- R9: When C > S (only possible at 16 bits), `undef` = 1, the result is 0, and all flag values and enables are 0.
- R10: `out_valid` equals `in_valid` delayed by one clock. The result, `undef`, `flag_val` and `flag_wen` load only on a cycle with `in_valid` high and otherwise hold. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe; loads the output registers |
| dst | input | DW (64) | Destination operand, low S bits used |
| src | input | DW (64) | Fill operand, low S bits used |
| cnt | input | CW (6) | Raw shift count |
| size_sel | input | 2 | Operand size code: 00=16, 01=32, 1x=64 |
| wide_mode | input | 1 | Allows a six-bit count for 64-bit operations |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | DW (64) | Shifted value, zero above the operand size |
| undef | output | 1 | Marks an undefined result and flag set |
| flag_val | output | 6 | Flags: 0 carry, 1 parity, 2 adjust, 3 zero, 4 sign, 5 overflow |
| flag_wen | output | 6 | Per-flag write enables, same bit order |

## Verification
On every cycle, the assertions check the timing of the strobe and that outputs hold between operations. They also check that an undefined operation enables no flag and returns zero, that an overflow enable always comes with a carry enable, and that a committed zero flag matches an all-zero result. The bit-exact funnel value, the count reduction that depends on mode, the carry source bit and the exact flag values at each operand size can only be shown by the bench. It compares every operation against its own model and covers directed corners: counts of zero, one and exactly the operand size, counts that wrap to zero, and overshoot at 16 bits.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
   typedef enum logic [1:0] {
      SZ_16  = 2'b00,
      SZ_32  = 2'b01,
      SZ_64  = 2'b10,
      SZ_64X = 2'b11
   } size_e;

   localparam int FL_CF = 0;
   localparam int FL_PF = 1;
   localparam int FL_AF = 2;
   localparam int FL_ZF = 3;
   localparam int FL_SF = 4;
   localparam int FL_OF = 5;
   localparam int NFLAG = 6;
endpackage

// File: rtl/fsh_count.sv
module fsh_count
   import fsh_pkg::*;
#(
   parameter int DW = 64,
   parameter int CW = 6,
   localparam int MW = $clog2(DW)
) (
   input  logic [CW-1:0] cnt,
   input  size_e         sz,
   input  logic          wide,
   output logic [MW-1:0] mcnt,
   output logic          over
);
   if (CW < MW) begin : g_cw_chk
      $error("fsh_count: count width too narrow");
   end

   always_comb begin
      if (sz[1] && wide) mcnt = cnt[MW-1:0];
      else               mcnt = {1'b0, cnt[MW-2:0]};
      over = (sz == SZ_16) && (mcnt > MW'(DW/4));
   end
endmodule

// File: rtl/fsh_core.sv
module fsh_core
   import fsh_pkg::*;
#(
   parameter int DW = 64,
   localparam int MW = $clog2(DW),
   localparam int NL = 3
) (
   input  logic [DW-1:0] dst,
   input  logic [DW-1:0] src,
   input  logic [MW-1:0] mcnt,
   input  size_e         sz,
   output logic [DW-1:0] res,
   output logic          cf_bit,
   output logic          dsign,
   output logic          rsign
);
   logic [DW-1:0] lane_res [NL];
   logic [NL-1:0] lane_cf, lane_ds, lane_rs;
   logic [MW-1:0] dm1;

   assign dm1 = mcnt - 1'b1;

   for (genvar g = 0; g < NL; g++) begin : g_lane
      localparam int W  = (DW / 4) << g;
      localparam int LW = $clog2(W);
      logic [2*W-1:0] cat;
      logic [W-1:0]   sh;
      logic [W-1:0]   dlo;
      assign dlo = dst[W-1:0];
      assign cat = {src[W-1:0], dlo};
      assign sh  = W'(cat >> mcnt);
      assign lane_res[g] = DW'(sh);
      assign lane_cf[g]  = dlo[dm1[LW-1:0]];
      assign lane_ds[g]  = dlo[W-1];
      assign lane_rs[g]  = sh[W-1];
   end

   always_comb begin
      int idx;
      idx = sz[1] ? 2 : (sz[0] ? 1 : 0);
      res    = lane_res[idx];
      cf_bit = lane_cf[idx];
      dsign  = lane_ds[idx];
      rsign  = lane_rs[idx];
   end
endmodule

// File: rtl/fsh_flags.sv
module fsh_flags
   import fsh_pkg::*;
#(
   parameter int DW = 64,
   localparam int MW = $clog2(DW)
) (
   input  logic [DW-1:0]    res,
   input  logic [MW-1:0]    mcnt,
   input  logic             over,
   input  logic             cf_bit,
   input  logic             dsign,
   input  logic             rsign,
   output logic [DW-1:0]    fin_res,
   output logic [NFLAG-1:0] fval,
   output logic [NFLAG-1:0] fwen
);
   logic shifted;
   assign shifted = (mcnt != '0) && !over;

   always_comb begin
      fin_res = over ? '0 : res;
      fval    = '0;
      fwen    = '0;
      if (shifted) begin
         fval[FL_CF] = cf_bit;
         fval[FL_PF] = ~^res[7:0];
         fval[FL_ZF] = (res == '0);
         fval[FL_SF] = rsign;
         fwen[FL_CF] = 1'b1;
         fwen[FL_PF] = 1'b1;
         fwen[FL_ZF] = 1'b1;
         fwen[FL_SF] = 1'b1;
         if (mcnt == MW'(1)) begin
            fval[FL_OF] = rsign ^ dsign;
            fwen[FL_OF] = 1'b1;
         end
      end
   end

   // R8
   always_comb begin
      af_quiet_chk: assert (fwen[FL_AF] == 1'b0 || $isunknown(fwen));
   end
endmodule

// File: rtl/funnel_rshift.sv
module funnel_rshift
   import fsh_pkg::*;
#(
   parameter int DW = 64,
   parameter int CW = 6,
   localparam int MW = $clog2(DW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [DW-1:0]    dst,
   input  logic [DW-1:0]    src,
   input  logic [CW-1:0]    cnt,
   input  logic [1:0]       size_sel,
   input  logic             wide_mode,
   output logic             out_valid,
   output logic [DW-1:0]    result,
   output logic             undef,
   output logic [NFLAG-1:0] flag_val,
   output logic [NFLAG-1:0] flag_wen
);
   if (DW != 64) begin : g_dw_chk
      $error("funnel_rshift: DW must be 64 for the 16/32/64 lanes");
   end

   logic [MW-1:0]    mcnt;
   logic             over, cf_bit, dsign, rsign;
   logic [DW-1:0]    raw_res, fin_res;
   logic [NFLAG-1:0] fval, fwen;

   fsh_count #(.DW(DW), .CW(CW)) u_cnt (
      .cnt(cnt), .sz(size_e'(size_sel)), .wide(wide_mode),
      .mcnt(mcnt), .over(over)
   );

   fsh_core #(.DW(DW)) u_core (
      .dst(dst), .src(src), .mcnt(mcnt), .sz(size_e'(size_sel)),
      .res(raw_res), .cf_bit(cf_bit), .dsign(dsign), .rsign(rsign)
   );

   fsh_flags #(.DW(DW)) u_flags (
      .res(raw_res), .mcnt(mcnt), .over(over), .cf_bit(cf_bit),
      .dsign(dsign), .rsign(rsign),
      .fin_res(fin_res), .fval(fval), .fwen(fwen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         undef     <= 1'b0;
         flag_val  <= '0;
         flag_wen  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= fin_res;
            undef    <= over;
            flag_val <= fval;
            flag_wen <= fwen;
         end
      end
   end

   // R10
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result) && $stable(flag_wen) && $stable(undef));

   // R9
   undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> (flag_wen == '0) && (result == '0) && (flag_val == '0));

   // R7
   of_needs_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wen[FL_OF] |-> flag_wen[FL_CF]);

   // R6
   zf_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wen[FL_ZF] && flag_val[FL_ZF]) |-> (result == '0));
endmodule

// File: tb/funnel_rshift_test.sv
module funnel_rshift_test;
   localparam int PER = 10;
   localparam int DW  = 64;
   localparam int CW  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] dst = '0, src = '0;
   logic [CW-1:0] cnt = '0;
   logic [1:0]    size_sel = '0;
   logic          wide_mode = 1'b0;
   logic          out_valid, undef;
   logic [DW-1:0] result;
   logic [5:0]    flag_val, flag_wen;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(PER/2) clk = ~clk;

   funnel_rshift #(.DW(DW), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst(dst), .src(src),
      .cnt(cnt), .size_sel(size_sel), .wide_mode(wide_mode),
      .out_valid(out_valid), .result(result), .undef(undef),
      .flag_val(flag_val), .flag_wen(flag_wen)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [63:0] d, input logic [63:0] s, input logic [5:0] c,
                        input logic [1:0] sz, input logic w,
                        output logic [63:0] r, output logic u,
                        output logic [5:0] fv, output logic [5:0] fw);
      int S, mc;
      S  = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
      mc = (sz[1] && w) ? int'(c[5:0]) : int'(c[4:0]);
      r = '0; u = 1'b0; fv = '0; fw = '0;
      if (mc == 0) begin
         for (int i = 0; i < S; i++) r[i] = d[i];
      end else if (mc > S) begin
         u = 1'b1;
      end else begin
         for (int i = 0; i < S; i++) r[i] = (i < S - mc) ? d[i + mc] : s[i + mc - S];
         fv[0] = d[mc - 1];
         fv[1] = ~^r[7:0];
         fv[3] = (r == 64'd0);
         fv[4] = r[S - 1];
         fw = 6'b011011;
         if (mc == 1) begin
            fv[5] = r[S - 1] ^ d[S - 1];
            fw[5] = 1'b1;
         end
      end
   endtask

   task automatic run_op(input logic [63:0] d, input logic [63:0] s, input logic [5:0] c,
                         input logic [1:0] sz, input logic w, input string tag);
      logic [63:0] er; logic eu; logic [5:0] efv, efw;
      model(d, s, c, sz, w, er, eu, efv, efw);
      @(negedge clk);
      dst = d; src = s; cnt = c; size_sel = sz; wide_mode = w; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " R10 out_valid"}, 64'(out_valid), 64'd1);
      chk({tag, " R3 result"}, result, er);
      chk({tag, " R9 undef"}, 64'(undef), 64'(eu));
      chk({tag, " R5 carry"}, 64'({flag_wen[0], flag_val[0]}), 64'({efw[0], efv[0]}));
      chk({tag, " R6 sign/zero/parity"},
          64'({flag_wen[4], flag_wen[3], flag_wen[1], flag_val[4], flag_val[3], flag_val[1]}),
          64'({efw[4], efw[3], efw[1], efv[4], efv[3], efv[1]}));
      chk({tag, " R7 overflow"}, 64'({flag_wen[5], flag_val[5]}), 64'({efw[5], efv[5]}));
      chk({tag, " R8 adjust"}, 64'({flag_wen[2], flag_val[2]}), 64'd0);
   endtask

   initial begin
      #(PER * 150000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset valid", 64'(out_valid), 64'd0);
      chk("R10 reset result", result, 64'd0);
      chk("R10 reset flags", 64'({undef, flag_val, flag_wen}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 idle valid", 64'(out_valid), 64'd0);

      // R2 zero count keeps destination, no flags
      run_op(64'hFFFF_1234_8765_ABCD, 64'h1, 6'd0, 2'b01, 1'b1, "R2 zero");
      chk("R2 value", result, 64'h0000_0000_8765_ABCD);
      chk("R2 no enables", 64'(flag_wen), 64'd0);
      // R7 count one with sign change, 16-bit
      run_op(64'h0000_0000_0000_8001, 64'h0, 6'd1, 2'b00, 1'b0, "R7 c1");
      chk("R7 of set", 64'({flag_wen[5], flag_val[5]}), 64'b11);
      // R3 count equal to size at 16: all from source
      run_op(64'h0000_0000_0000_8000, 64'hAAAA_BBBB_CCCC_5A5A, 6'd16, 2'b00, 1'b0, "R3 c16");
      chk("R3 full fill", result, 64'h5A5A);
      chk("R5 carry top", 64'(flag_val[0]), 64'd1);
      // R9 overshoot at 16
      run_op(64'hFFFF, 64'hFFFF, 6'd17, 2'b00, 1'b0, "R9 c17");
      chk("R9 marked", 64'(undef), 64'd1);
      run_op(64'h1234, 64'hFFFF, 6'd31, 2'b00, 1'b1, "R9 c31");
      // R1 count 32 at 64-bit without wide mode wraps to zero
      run_op(64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd32, 2'b10, 1'b0, "R1 narrow");
      chk("R1 wrapped noop", result, 64'h0123_4567_89AB_CDEF);
      run_op(64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0000, 6'd32, 2'b10, 1'b1, "R1 wide");
      chk("R1 wide shift", result, 64'h0000_0000_0123_4567);
      run_op(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 6'd63, 2'b11, 1'b1, "R1 c63");
      // R4 upper bits zero at 32-bit
      run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd5, 2'b01, 1'b0, "R4 c5");
      chk("R4 upper clear", result[63:32], 64'd0);
      // R6 zero result
      run_op(64'h0000_0000_0000_00FF, 64'h0, 6'd8, 2'b00, 1'b0, "R6 zero");
      chk("R6 zf", 64'(flag_val[3]), 64'd1);

      // R10 hold: no strobe, new inputs, outputs stay
      begin
         logic [63:0] keep;
         keep = result;
         @(negedge clk);
         dst = 64'hDEAD_BEEF_DEAD_BEEF; cnt = 6'd3; size_sel = 2'b10; wide_mode = 1'b1;
         @(negedge clk);
         @(negedge clk);
         chk("R10 hold result", result, keep);
         chk("R10 hold valid", 64'(out_valid), 64'd0);
      end

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [63:0] d, s;
         logic [5:0] c;
         d = {$urandom, $urandom};
         s = {$urandom, $urandom};
         c = 6'($urandom);
         if (n % 5 == 0) c = 6'($urandom % 3);
         run_op(d, s, c, 2'($urandom), 1'($urandom), "rand");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule